// File: doc/BRIEF.md
# Serial Mailbox Program Boot Loader

This block fills the instruction memory of a processor core from a host controller after every reset. The host clocks bytes in over a three-wire synchronous serial input: a serial clock, a data line and a ready strobe. Received bytes collect in a 16-byte mailbox, which is organised as eight 16-bit entries. Those eight entries make up exactly four 32-bit instructions.

When the host raises the ready strobe with a full mailbox, the four instructions are written into the program RAM, one per clock cycle, at the next free addresses. After 80 such loads all 320 words are present. The block then leaves boot mode on its own, gives the core a one-cycle start pulse and keeps a running indicator high until the next reset.

A strobe that arrives with an incomplete mailbox is flagged and the partial data is dropped. All traffic that arrives after the boot has finished has no effect.

Top module: `prog_boot_loader`

## Requirements
- R1: While reset is held and on the first clock after it is released, boot_mode is 1 and core_run, core_start, load_err and pram_we are 0.
- R2: A serial bit is taken from sdata_in at each rising edge of sclk_in, after both inputs have passed through synchronizer flops. Eight bits form a byte, and the first bit received becomes bit 7.
- R3: Within one load, the instruction at position k (k = 0..3) is made of received bytes 4k to 4k+3. Byte 4k goes to bits 31:24 and byte 4k+3 goes to bits 7:0.
- R4: A rising edge of srdy_in with 16 bytes in the mailbox causes four writes on consecutive clock cycles. The addresses rise by one from the next free address, and the first load goes to address 0.
- R5: A rising edge of srdy_in with fewer than 16 complete bytes performs no write and does not advance the next free address. It discards all collected bytes and bits, and it sets load_err, which stays 1 until reset.
- R6: In the clock cycle after the write to address 319, boot_mode is 0, core_start is 1 for exactly that one cycle, and core_run is 1. core_run then stays 1 until reset.
- R7: Once boot_mode is 0, serial bytes and ready strobes cause no write, and the outputs do not change.
- R8: Bytes that arrive while the mailbox already holds 16 bytes are dropped. The next load commits the first 16 bytes.
- R9: pram_addr is at most 319 whenever pram_we is 1, and exactly 320 writes occur during a complete boot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset. Puts the block back into boot mode. |
| sclk_in | input | 1 | Host serial clock. Data is taken on its rising edge. |
| sdata_in | input | 1 | Host serial data, most significant bit first |
| srdy_in | input | 1 | Host ready strobe. A rising edge commits the mailbox. |
| pram_we | output | 1 | Program RAM write enable |
| pram_addr | output | 9 | Program RAM write address |
| pram_wdata | output | 32 | Program RAM write data |
| boot_mode | output | 1 | 1 while the program is being loaded |
| core_start | output | 1 | One-cycle pulse when loading is complete |
| core_run | output | 1 | Stays 1 from the end of the boot until reset |
| load_err | output | 1 | Sticky flag for a ready strobe that arrived with a partial mailbox |

## Verification
The first load carries all-ones, all-zeros, end-bit-only and ascending-nibble words. These tell a correct MSB-first byte assembly apart from reversed bit or byte orders. The remaining loads carry hashed, address-dependent words, so a skipped, repeated or misplaced address shows up as a data mismatch.

The irregular patterns are placed between good loads:
- a strobe after five bytes,
- a strobe after three loose bits,
- a 17-byte burst.

After each of them, the next good load must land at an unchanged address with untouched data. This separates correct discard behaviour from leftover bytes or bits leaking into the following load. Traffic sent after the boot finishes must produce no write at all.

// File: rtl/boot_pkg.sv
package boot_pkg;
   localparam int BYTE_W = 8;

   typedef enum logic [1:0] {
      ST_LOAD   = 2'd0,
      ST_COMMIT = 2'd1,
      ST_DONE   = 2'd2
   } boot_state_e;
endpackage

// File: rtl/boot_ser_rx.sv
module boot_ser_rx
   import boot_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sclk_in,
   input  logic              sdata_in,
   input  logic              srdy_in,
   input  logic              enable,
   input  logic              flush,
   output logic              byte_vld,
   output logic [BYTE_W-1:0] byte_val,
   output logic              rdy_rise
);
   localparam int CNT_W = $clog2(BYTE_W);

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic [SYNC_STAGES-1:0] sclk_sh, sdat_sh, srdy_sh;
   logic                   sclk_prev, srdy_prev;
   logic                   sclk_s, sdat_s, srdy_s;
   logic [CNT_W-1:0]       bit_cnt;
   logic [BYTE_W-1:0]      shreg;

   generate
      for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sclk_sh[i] <= 1'b0;
               sdat_sh[i] <= 1'b0;
               srdy_sh[i] <= 1'b0;
            end else if (i == 0) begin
               sclk_sh[i] <= sclk_in;
               sdat_sh[i] <= sdata_in;
               srdy_sh[i] <= srdy_in;
            end else begin
               sclk_sh[i] <= sclk_sh[(i == 0) ? 0 : i-1];
               sdat_sh[i] <= sdat_sh[(i == 0) ? 0 : i-1];
               srdy_sh[i] <= srdy_sh[(i == 0) ? 0 : i-1];
            end
         end
      end
   endgenerate

   assign sclk_s = sclk_sh[SYNC_STAGES-1];
   assign sdat_s = sdat_sh[SYNC_STAGES-1];
   assign srdy_s = srdy_sh[SYNC_STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_prev <= 1'b0;
         srdy_prev <= 1'b0;
      end else begin
         sclk_prev <= sclk_s;
         srdy_prev <= srdy_s;
      end
   end

   assign rdy_rise = srdy_s & ~srdy_prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_cnt  <= '0;
         shreg    <= '0;
         byte_vld <= 1'b0;
         byte_val <= '0;
      end else begin
         byte_vld <= 1'b0;
         if (flush) begin
            bit_cnt <= '0;
         end else if (enable && sclk_s && !sclk_prev) begin
            shreg   <= {shreg[BYTE_W-2:0], sdat_s};
            bit_cnt <= bit_cnt + 1'b1;
            if (bit_cnt == CNT_W'(BYTE_W-1)) begin
               byte_vld <= 1'b1;
               byte_val <= {shreg[BYTE_W-2:0], sdat_s};
            end
         end
      end
   end

   // R2: a byte needs eight serial edges, so two strobes never touch
   p_byte_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
      byte_vld |=> !byte_vld);
endmodule

// File: rtl/boot_mailbox.sv
module boot_mailbox
   import boot_pkg::*;
#(
   parameter int MB_ENTRIES = 8,
   parameter int MB_ENTRY_W = 16,
   parameter int INSTR_W    = 32
) (
   input  logic                                               clk,
   input  logic                                               rst_n,
   input  logic                                               byte_vld,
   input  logic [BYTE_W-1:0]                                  byte_val,
   input  logic                                               clear,
   input  logic [$clog2(MB_ENTRIES*MB_ENTRY_W/INSTR_W)-1:0]   rd_idx,
   output logic                                               full,
   output logic [INSTR_W-1:0]                                 rd_word
);
   localparam int BPE      = MB_ENTRY_W / BYTE_W;
   localparam int MB_BYTES = MB_ENTRIES * BPE;
   localparam int EPI      = INSTR_W / MB_ENTRY_W;
   localparam int IPL      = MB_ENTRIES / EPI;
   localparam int CNT_W    = $clog2(MB_BYTES + 1);

   generate
      if (MB_ENTRY_W % BYTE_W != 0 || INSTR_W % MB_ENTRY_W != 0 ||
          MB_ENTRIES % EPI != 0 || IPL < 2) begin : g_bad_shape
         $error("mailbox shape does not divide into whole instructions");
      end
   endgenerate

   logic [MB_ENTRY_W-1:0] entries [MB_ENTRIES];
   logic [CNT_W-1:0]      cnt;
   logic [INSTR_W-1:0]    words [IPL];

   assign full = (cnt == CNT_W'(MB_BYTES));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         for (int e = 0; e < MB_ENTRIES; e++) entries[e] <= '0;
      end else if (clear) begin
         cnt <= '0;
      end else if (byte_vld && !full) begin
         cnt <= cnt + 1'b1;
         for (int e = 0; e < MB_ENTRIES; e++)
            for (int l = 0; l < BPE; l++)
               if (cnt == CNT_W'(e*BPE + l))
                  entries[e][(BPE-1-l)*BYTE_W +: BYTE_W] <= byte_val;
      end
   end

   generate
      for (genvar k = 0; k < IPL; k++) begin : g_word
         for (genvar j = 0; j < EPI; j++) begin : g_part
            assign words[k][(EPI-1-j)*MB_ENTRY_W +: MB_ENTRY_W] = entries[k*EPI + j];
         end
      end
   endgenerate

   assign rd_word = words[rd_idx];

   // R8: the fill count never passes the mailbox size
   p_cnt_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CNT_W'(MB_BYTES));
   // R8: a full mailbox keeps its count until it is cleared
   p_full_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      full && !clear |=> full);
endmodule

// File: rtl/boot_ctrl.sv
module boot_ctrl
   import boot_pkg::*;
#(
   parameter int PROG_WORDS = 320,
   parameter int IPL        = 4
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            rdy_rise,
   input  logic                            mb_full,
   output logic                            mb_clear,
   output logic [$clog2(IPL)-1:0]          rd_idx,
   output logic                            pram_we,
   output logic [$clog2(PROG_WORDS)-1:0]   pram_addr,
   output logic                            boot_mode,
   output logic                            core_start,
   output logic                            core_run,
   output logic                            load_err
);
   localparam int ADDR_W    = $clog2(PROG_WORDS);
   localparam int IDX_W     = $clog2(IPL);
   localparam int LAST      = PROG_WORDS - 1;
   localparam int LAST_BASE = PROG_WORDS - IPL;

   generate
      if (PROG_WORDS % IPL != 0) begin : g_bad_count
         $error("PROG_WORDS must be a whole number of mailbox loads");
      end
   endgenerate

   boot_state_e      st;
   logic [ADDR_W-1:0] base_q;
   logic [IDX_W-1:0]  widx_q;
   logic              start_q, err_q;

   assign mb_clear   = (st == ST_LOAD) && rdy_rise;
   assign rd_idx     = widx_q;
   assign pram_we    = (st == ST_COMMIT);
   assign pram_addr  = base_q + ADDR_W'(widx_q);
   assign boot_mode  = (st != ST_DONE);
   assign core_run   = (st == ST_DONE);
   assign core_start = start_q;
   assign load_err   = err_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ST_LOAD;
         base_q  <= '0;
         widx_q  <= '0;
         start_q <= 1'b0;
         err_q   <= 1'b0;
      end else begin
         start_q <= 1'b0;
         unique case (st)
            ST_LOAD: begin
               if (rdy_rise) begin
                  if (mb_full) begin
                     st     <= ST_COMMIT;
                     widx_q <= '0;
                  end else begin
                     err_q <= 1'b1;
                  end
               end
            end
            ST_COMMIT: begin
               if (widx_q == IDX_W'(IPL-1)) begin
                  widx_q <= '0;
                  if (base_q == ADDR_W'(LAST_BASE)) begin
                     st      <= ST_DONE;
                     start_q <= 1'b1;
                  end else begin
                     st     <= ST_LOAD;
                     base_q <= base_q + ADDR_W'(IPL);
                  end
               end else begin
                  widx_q <= widx_q + 1'b1;
               end
            end
            default: st <= ST_DONE;
         endcase
      end
   end

   // R9: writes stay inside the program memory
   p_addr_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
      pram_we |-> pram_addr <= ADDR_W'(LAST));
   // R4: back-to-back writes step the address by one
   p_addr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      pram_we && $past(pram_we) |-> pram_addr == $past(pram_addr) + 1'b1);
   // R6: start follows the write of the last word
   p_start_after_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
      core_start |-> $past(pram_we) && $past(pram_addr) == ADDR_W'(LAST));
   // R6: start is a single-cycle pulse
   p_start_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      core_start |=> !core_start);
   // R6: the running indicator holds until reset
   p_run_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      core_run |=> core_run);
   // R5: the error flag is sticky
   p_err_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      load_err |=> load_err);
endmodule

// File: rtl/prog_boot_loader.sv
module prog_boot_loader
   import boot_pkg::*;
#(
   parameter int PROG_WORDS  = 320,
   parameter int INSTR_W     = 32,
   parameter int MB_ENTRIES  = 8,
   parameter int MB_ENTRY_W  = 16,
   parameter int SYNC_STAGES = 2,
   localparam int ADDR_W     = $clog2(PROG_WORDS)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sclk_in,
   input  logic               sdata_in,
   input  logic               srdy_in,
   output logic               pram_we,
   output logic [ADDR_W-1:0]  pram_addr,
   output logic [INSTR_W-1:0] pram_wdata,
   output logic               boot_mode,
   output logic               core_start,
   output logic               core_run,
   output logic               load_err
);
   localparam int IPL   = MB_ENTRIES * MB_ENTRY_W / INSTR_W;
   localparam int IDX_W = $clog2(IPL);

   logic              byte_vld, rdy_rise, mb_full, mb_clear;
   logic [BYTE_W-1:0] byte_val;
   logic [IDX_W-1:0]  rd_idx;

   boot_ser_rx #(.SYNC_STAGES(SYNC_STAGES)) u_rx (
      .clk      (clk),
      .rst_n    (rst_n),
      .sclk_in  (sclk_in),
      .sdata_in (sdata_in),
      .srdy_in  (srdy_in),
      .enable   (boot_mode),
      .flush    (mb_clear),
      .byte_vld (byte_vld),
      .byte_val (byte_val),
      .rdy_rise (rdy_rise)
   );

   boot_mailbox #(
      .MB_ENTRIES (MB_ENTRIES),
      .MB_ENTRY_W (MB_ENTRY_W),
      .INSTR_W    (INSTR_W)
   ) u_mb (
      .clk      (clk),
      .rst_n    (rst_n),
      .byte_vld (byte_vld),
      .byte_val (byte_val),
      .clear    (mb_clear),
      .rd_idx   (rd_idx),
      .full     (mb_full),
      .rd_word  (pram_wdata)
   );

   boot_ctrl #(.PROG_WORDS(PROG_WORDS), .IPL(IPL)) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .rdy_rise   (rdy_rise),
      .mb_full    (mb_full),
      .mb_clear   (mb_clear),
      .rd_idx     (rd_idx),
      .pram_we    (pram_we),
      .pram_addr  (pram_addr),
      .boot_mode  (boot_mode),
      .core_start (core_start),
      .core_run   (core_run),
      .load_err   (load_err)
   );
endmodule

// File: tb/prog_boot_loader_tb_top.sv
module prog_boot_loader_tb_top;
   localparam int WORDS = 320;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sclk_in = 1'b0, sdata_in = 1'b0, srdy_in = 1'b0;
   logic        pram_we, boot_mode, core_start, core_run, load_err;
   logic [8:0]  pram_addr;
   logic [31:0] pram_wdata;

   int total = 0;
   int bad = 0;
   int writes = 0;
   int pend = 0;
   bit finished = 0;

   logic [8:0]  exp_a [$];
   logic [31:0] exp_d [$];

   always #2 clk = ~clk;

   prog_boot_loader dut_i (
      .clk(clk), .rst_n(rst_n), .sclk_in(sclk_in), .sdata_in(sdata_in),
      .srdy_in(srdy_in), .pram_we(pram_we), .pram_addr(pram_addr),
      .pram_wdata(pram_wdata), .boot_mode(boot_mode), .core_start(core_start),
      .core_run(core_run), .load_err(load_err)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // R2: one serial bit, data set up before the rising serial clock
   task automatic send_bit(input logic b);
      sdata_in = b;
      repeat (3) @(posedge clk);
      sclk_in = 1'b1;
      repeat (3) @(posedge clk);
      sclk_in = 1'b0;
   endtask

   task automatic send_byte(input logic [7:0] v);
      for (int i = 7; i >= 0; i--) send_bit(v[i]);
   endtask

   task automatic strobe();
      srdy_in = 1'b1;
      repeat (6) @(posedge clk);
      srdy_in = 1'b0;
      repeat (8) @(posedge clk);
   endtask

   function automatic logic [31:0] hash_word(input int a);
      return (32'(a) * 32'h9E3779B1) ^ 32'h5A3CC3A5;
   endfunction

   // R3/R4: send one load, push what the RAM should receive
   task automatic send_load(input int base, input logic [31:0] w0, input logic [31:0] w1,
                            input logic [31:0] w2, input logic [31:0] w3, input bit expect_write);
      logic [31:0] w [4];
      w[0] = w0; w[1] = w1; w[2] = w2; w[3] = w3;
      for (int k = 0; k < 4; k++) begin
         for (int b = 3; b >= 0; b--) send_byte(w[k][b*8 +: 8]);
         if (expect_write) begin
            exp_a.push_back(9'(base + k));
            exp_d.push_back(w[k]);
         end
      end
   endtask

   // scoreboard monitor
   initial begin
      forever begin
         @(negedge clk);
         if (pend == 1) begin
            chk(core_start && !boot_mode && core_run, "R6", "start/boot/run after last write",
                {29'd0, core_start, boot_mode, core_run}, 32'h5);
            pend = 2;
         end else if (pend == 2) begin
            chk(!core_start && core_run, "R6", "start pulse width / run held",
                {30'd0, core_start, core_run}, 32'h1);
            pend = 0;
         end
         if (pram_we === 1'b1) begin
            writes++;
            if (exp_a.size() == 0) begin
               chk(1'b0, "R7", "unexpected write addr", 32'(pram_addr), 32'hFFFF_FFFF);
            end else begin
               logic [8:0]  ea;
               logic [31:0] ed;
               ea = exp_a.pop_front();
               ed = exp_d.pop_front();
               chk(pram_addr == ea, "R4", "write address", 32'(pram_addr), 32'(ea));
               chk(pram_wdata == ed, "R3", "write data (R2 bit order)", pram_wdata, ed);
               if (ea == 9'(WORDS-1)) pend = 1;
            end
         end
      end
   end

   // watchdog
   initial begin
      repeat (190000) @(posedge clk);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      int base;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1: state while reset is held
      chk(boot_mode && !core_run && !core_start && !load_err && !pram_we, "R1", "reset outputs",
          {27'd0, boot_mode, core_run, core_start, load_err, pram_we}, 32'h10);
      rst_n = 1'b1;
      @(negedge clk);
      chk(boot_mode && !core_run && !core_start && !load_err && !pram_we, "R1", "after reset release",
          {27'd0, boot_mode, core_run, core_start, load_err, pram_we}, 32'h10);

      // first load: bit/byte order patterns
      send_load(0, 32'hFFFF_FFFF, 32'h0000_0000, 32'h8000_0001, 32'h0123_4567, 1'b1);
      strobe();

      // R5: strobe after five bytes
      for (int i = 0; i < 5; i++) send_byte(8'hEE);
      strobe();
      @(negedge clk);
      chk(load_err, "R5", "error flag after short load", {31'd0, load_err}, 32'h1);
      chk(exp_a.size() == 0, "R5", "queue drained, no write", 32'(exp_a.size()), 32'h0);

      // next good load lands at 4 with clean data
      send_load(4, hash_word(4), hash_word(5), hash_word(6), hash_word(7), 1'b1);
      strobe();

      // R5: strobe after three loose bits discards them
      send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
      strobe();
      send_load(8, hash_word(8), hash_word(9), hash_word(10), hash_word(11), 1'b1);
      strobe();

      // R8: 17th byte dropped
      send_load(12, hash_word(12), hash_word(13), hash_word(14), hash_word(15), 1'b1);
      send_byte(8'h77);
      strobe();

      base = 16;
      while (base < WORDS) begin
         send_load(base, hash_word(base), hash_word(base+1), hash_word(base+2),
                   hash_word(base+3), 1'b1);
         strobe();
         base += 4;
      end
      repeat (4) @(posedge clk);
      @(negedge clk);
      chk(writes == WORDS, "R9", "write count for full boot", 32'(writes), 32'(WORDS));
      chk(exp_a.size() == 0, "R4", "all expected writes seen", 32'(exp_a.size()), 32'h0);
      chk(!boot_mode && core_run, "R6", "run held after boot",
          {30'd0, boot_mode, core_run}, 32'h1);
      chk(load_err, "R5", "error flag still set", {31'd0, load_err}, 32'h1);

      // R7: traffic after completion
      send_load(0, 32'hDEAD_BEEF, 32'h1, 32'h2, 32'h3, 1'b0);
      strobe();
      @(negedge clk);
      chk(writes == WORDS, "R7", "no write after boot", 32'(writes), 32'(WORDS));
      chk(!boot_mode && core_run && !core_start, "R7", "outputs unchanged after boot",
          {29'd0, boot_mode, core_run, core_start}, 32'h2);

      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule